// File: doc/BRIEF.md
# Keyed Software Watchdog with Interrupt Vector

The block is a watchdog timer that runs on the bus clock. Once enabled, it counts toward one of eight power-of-two timeout periods. Software keeps it quiet by writing a two-byte key to the service address. If the count expires before the key arrives, the block raises an interrupt request and holds it. When the interrupt controller acknowledges, the block drives a programmable 8-bit vector.

The timeout selection in the control register is staged. A newly written period only takes effect when the next complete key pair arrives, and that same key pair also restarts the count.

If the interrupt is still unacknowledged when a further full period expires, and the transfer-acknowledge option is set, the block pulses a transfer-acknowledge output. This lets a stalled bus cycle finish. The block also records that event in a sticky flag that is cleared by writing one to it.

Top module: `swdog_top`

## Requirements
- R1: After reset, irq_o and ta_o are 0, the control register reads 0x00 (watchdog off, minimum period pending and active), and the vector register holds 0x0F.
- R2: While the enable bit (control bit 0) is 1, irq_o rises exactly 2^E clocks after the clock edge that enabled counting, restarted it, or last expired it, where E is the active period exponent.
- R3: The active period is set by the prescale bit (control bit 1) and the select field (control bits 3:2). The exponents are 9, 11, 13 and 15 for prescale 0 with select 0 to 3, and 22, 24, 26 and 28 for prescale 1. Parameter EXP_SUB_LO is subtracted from the low group and EXP_SUB_HI from the high group.
- R4: Writing 0x55 and then 0xAA to the service address (1) restarts the count. A repeated 0x55 keeps the key armed. Any other value written to the service address drops the key back to idle, and a following 0xAA then does nothing.
- R5: Writes to the prescale and select bits are held as pending. They become the active period on the edge that completes a valid key pair.
- R6: irq_o stays 1 from expiry until iack_i is sampled high. A sampled iack_i clears it on that edge, unless a new expiry falls on the same edge.
- R7: While iack_i is 1, vec_o shows the vector register; otherwise vec_o is 0. The vector register (address 2) is write-only and reads as 0.
- R8: When the transfer-acknowledge enable (control bit 4) is 1 and an expiry occurs while irq_o is already 1 and not being acknowledged, ta_o is 1 for exactly one clock after that edge.
- R9: With control bit 4 at 0, ta_o never asserts.
- R10: The status flag (control bit 5) is set on the same edge as ta_o. Writing 1 to bit 5 clears it, and writing 0 leaves it unchanged.
- R11: Control bits 7:6 always read as 0, and the service address reads as 0.
- R12: With the enable bit at 0 the count is held at zero and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | bus clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| wr_en_i | input | 1 | register write strobe |
| addr_i | input | 2 | register address: 0 control, 1 service, 2 vector |
| wdata_i | input | 8 | write data |
| rdata_o | output | 8 | read data for addr_i (combinational) |
| irq_o | output | 1 | watchdog interrupt request |
| iack_i | input | 1 | interrupt acknowledge |
| vec_o | output | 8 | interrupt vector during acknowledge |
| ta_o | output | 1 | second-stage transfer acknowledge pulse |

## Verification
The bench builds the block with EXP_SUB_LO = 6 and EXP_SUB_HI = 16. This turns the low group of periods into 8, 32, 128 and 512 clocks and the high group into 64, 256, 1024 and 4096 clocks. At these lengths every expiry can be checked on its exact cycle, including the longest high-group period. It also becomes cheap to reach the second-stage transfer acknowledge and the timing of pending-period commits. Both groups keep their relative ordering, so a wrong table entry or a wrong group shows up as a shifted expiry cycle.

// File: rtl/swdog_pkg.sv
package swdog_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_SVC  = 2'd1;
  localparam logic [1:0] ADDR_VEC  = 2'd2;

  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;
  localparam logic [7:0] VEC_RST  = 8'h0F;

  typedef enum logic {KEY_IDLE, KEY_ARMED} key_st_e;

  // idx = {prescale, select}
  function automatic int unsigned tmo_exp(input int unsigned idx,
                                          input int unsigned sub_lo,
                                          input int unsigned sub_hi);
    if (idx >= 4) return 22 + 2 * (idx - 4) - sub_hi;
    else          return 9 + 2 * idx - sub_lo;
  endfunction

  function automatic int unsigned max_exp(input int unsigned sub_lo,
                                          input int unsigned sub_hi);
    int unsigned a, b;
    a = tmo_exp(3, sub_lo, sub_hi);
    b = tmo_exp(7, sub_lo, sub_hi);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/swdog_keyseq.sv
module swdog_keyseq
  import swdog_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       svc_wr_i,
  input  logic [7:0] data_i,
  output logic       done_o
);
  key_st_e st_q, st_d;

  always_comb begin
    st_d   = st_q;
    done_o = 1'b0;
    if (svc_wr_i) begin
      if (data_i == KEY_ARM) begin
        st_d = KEY_ARMED;
      end else begin
        st_d   = KEY_IDLE;
        done_o = (st_q == KEY_ARMED) && (data_i == KEY_FIRE);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= KEY_IDLE;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/swdog_regs.sv
module swdog_regs
  import swdog_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       commit_i,
  input  logic       ta_fire_i,
  output logic       en_o,
  output logic       pre_o,
  output logic [1:0] sel_o,
  output logic       ta_en_o,
  output logic       ta_flag_o,
  output logic [7:0] vec_o,
  output logic [7:0] rdata_o
);
  logic       pre_pend_q;
  logic [1:0] sel_pend_q;
  logic       wr_ctrl, wr_vec;

  assign wr_ctrl = wr_en_i && (addr_i == ADDR_CTRL);
  assign wr_vec  = wr_en_i && (addr_i == ADDR_VEC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o       <= 1'b0;
      ta_en_o    <= 1'b0;
      pre_pend_q <= 1'b0;
      sel_pend_q <= 2'd0;
      pre_o      <= 1'b0;
      sel_o      <= 2'd0;
      ta_flag_o  <= 1'b0;
      vec_o      <= VEC_RST;
    end else begin
      if (wr_ctrl) begin
        en_o       <= wdata_i[0];
        pre_pend_q <= wdata_i[1];
        sel_pend_q <= wdata_i[3:2];
        ta_en_o    <= wdata_i[4];
        if (wdata_i[5]) ta_flag_o <= 1'b0;
      end
      if (ta_fire_i) ta_flag_o <= 1'b1;
      if (wr_vec)    vec_o     <= wdata_i;
      // staged period becomes live only on a completed key pair
      if (commit_i) begin
        pre_o <= pre_pend_q;
        sel_o <= sel_pend_q;
      end
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (addr_i == ADDR_CTRL)
      rdata_o = {2'b00, ta_flag_o, ta_en_o, sel_pend_q, pre_pend_q, en_o};
  end
endmodule

// File: rtl/swdog_timer.sv
module swdog_timer
  import swdog_pkg::*;
#(
  parameter int unsigned EXP_SUB_LO = 0,
  parameter int unsigned EXP_SUB_HI = 0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       pre_i,
  input  logic [1:0] sel_i,
  input  logic       restart_i,
  output logic       expire_o
);
  localparam int unsigned CNT_W = max_exp(EXP_SUB_LO, EXP_SUB_HI);
  localparam int unsigned N_SEL = 8;

  logic [CNT_W-1:0] mask_tab [N_SEL];
  logic [CNT_W-1:0] cnt_q;
  logic             hit;

  for (genvar g = 0; g < N_SEL; g++) begin : g_tab
    localparam int unsigned E = tmo_exp(g, EXP_SUB_LO, EXP_SUB_HI);
    assign mask_tab[g] = CNT_W'((64'd1 << E) - 64'd1);
  end

  assign hit      = en_i && (cnt_q == mask_tab[{pre_i, sel_i}]);
  assign expire_o = hit && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (!en_i || restart_i || hit)  cnt_q <= '0;
    else                                 cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/swdog_irq.sv
module swdog_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic iack_i,
  input  logic ta_en_i,
  output logic irq_o,
  output logic ta_o,
  output logic ta_fire_o
);
  // second expiry with the request still ignored
  assign ta_fire_o = expire_i && irq_o && !iack_i && ta_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= 1'b0;
      ta_o  <= 1'b0;
    end else begin
      if (expire_i)    irq_o <= 1'b1;
      else if (iack_i) irq_o <= 1'b0;
      ta_o <= ta_fire_o;
    end
  end
endmodule

// File: rtl/swdog_top.sv
module swdog_top #(
  parameter int unsigned EXP_SUB_LO = 0,
  parameter int unsigned EXP_SUB_HI = 0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_o,
  input  logic       iack_i,
  output logic [7:0] vec_o,
  output logic       ta_o
);
  logic       svc_wr, commit, expire, ta_fire;
  logic       en, pre, ta_en, ta_flag;
  logic [1:0] sel;
  logic [7:0] vec_q;

  assign svc_wr = wr_en_i && (addr_i == swdog_pkg::ADDR_SVC);

  swdog_keyseq u_key (
    .clk_i, .rst_ni,
    .svc_wr_i (svc_wr),
    .data_i   (wdata_i),
    .done_o   (commit)
  );

  swdog_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .commit_i  (commit),
    .ta_fire_i (ta_fire),
    .en_o      (en),
    .pre_o     (pre),
    .sel_o     (sel),
    .ta_en_o   (ta_en),
    .ta_flag_o (ta_flag),
    .vec_o     (vec_q),
    .rdata_o   (rdata_o)
  );

  swdog_timer #(.EXP_SUB_LO(EXP_SUB_LO), .EXP_SUB_HI(EXP_SUB_HI)) u_tmr (
    .clk_i, .rst_ni,
    .en_i      (en),
    .pre_i     (pre),
    .sel_i     (sel),
    .restart_i (commit),
    .expire_o  (expire)
  );

  swdog_irq u_irq (
    .clk_i, .rst_ni,
    .expire_i  (expire),
    .iack_i    (iack_i),
    .ta_en_i   (ta_en),
    .irq_o     (irq_o),
    .ta_o      (ta_o),
    .ta_fire_o (ta_fire)
  );

  assign vec_o = iack_i ? vec_q : 8'h00;
endmodule

// File: rtl/swdog_chk.sv
module swdog_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic iack_i,
  input logic irq_o,
  input logic ta_o,
  input logic expire,
  input logic ta_en,
  input logic ta_flag
);
  a_r6_irq_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !iack_i |=> irq_o);

  a_r6_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iack_i && !expire |=> !irq_o);

  a_r2_rise_from_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o && !expire |=> !irq_o);

  a_r8_ta_while_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ta_o |-> irq_o);

  a_r8_ta_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ta_o |=> !ta_o);

  a_r9_ta_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ta_en |=> !ta_o);

  a_r10_flag_with_ta: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ta_o |-> ta_flag);
endmodule

bind swdog_top swdog_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .iack_i  (iack_i),
  .irq_o   (irq_o),
  .ta_o    (ta_o),
  .expire  (expire),
  .ta_en   (ta_en),
  .ta_flag (ta_flag)
);

// File: tb/sim_swdog_top.sv
`timescale 1ns/1ps
module sim_swdog_top;
  localparam int unsigned SUB_LO = 6;
  localparam int unsigned SUB_HI = 16;
  localparam logic [1:0] A_CTRL = 2'd0, A_SVC = 2'd1, A_VEC = 2'd2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata, vec;
  logic       irq, iack = 1'b0, ta;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  swdog_top #(.EXP_SUB_LO(SUB_LO), .EXP_SUB_HI(SUB_HI)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .iack_i(iack),
    .vec_o(vec), .ta_o(ta)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; iack = 1'b0;
    wait_n(2);
    rst_n = 1'b1;
    wait_n(1);
  endtask

  // called at a negedge; write lands on the next posedge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic service();
    wr(A_SVC, 8'h55);
    wr(A_SVC, 8'hAA);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    chk("R1 irq after reset", irq, 0);
    chk("R1 ta after reset", ta, 0);
    rd(A_CTRL, d); chk("R1 ctrl after reset", d, 8'h00);
    iack = 1'b1; #1; chk("R1/R7 vector reset value", vec, 8'h0F);
    iack = 1'b0; #1; chk("R7 vec idle", vec, 8'h00);
    rd(A_VEC, d); chk("R7 vector write-only", d, 8'h00);
    rd(A_SVC, d); chk("R11 service reads 0", d, 8'h00);
  endtask

  task automatic t_basic();
    do_reset();
    wr(A_CTRL, 8'h01);
    wait_n(7); chk("R2/R3 min period not yet", irq, 0);
    wait_n(1); chk("R2/R3 min period expiry", irq, 1);
    wait_n(3); chk("R6 irq held", irq, 1);
    iack = 1'b1; #1; chk("R7 vec on ack", vec, 8'h0F);
    @(negedge clk); iack = 1'b0;
    chk("R6 ack clears", irq, 0);
    wr(A_VEC, 8'h5A);
    wait_n(2); chk("R2 periodic not yet", irq, 0);
    wait_n(1); chk("R2 periodic expiry", irq, 1);
    iack = 1'b1; #1; chk("R7 programmed vector", vec, 8'h5A);
    @(negedge clk); iack = 1'b0;
  endtask

  task automatic t_service();
    do_reset();
    wr(A_CTRL, 8'h01);
    wait_n(5);
    service();
    wait_n(7); chk("R4 restart delays expiry", irq, 0);
    wait_n(1); chk("R4 expiry after restart", irq, 1);
  endtask

  task automatic t_badseq();
    do_reset();
    wr(A_CTRL, 8'h01);
    wr(A_SVC, 8'h55); wr(A_SVC, 8'h12); wr(A_SVC, 8'hAA);
    wait_n(4); chk("R4 broken key no restart (pre)", irq, 0);
    wait_n(1); chk("R4 broken key no restart", irq, 1);
  endtask

  task automatic t_repeat();
    do_reset();
    wr(A_CTRL, 8'h01);
    wr(A_SVC, 8'h55); wr(A_SVC, 8'h55); wr(A_SVC, 8'hAA);
    wait_n(7); chk("R4 repeated arm restarts", irq, 0);
    wait_n(1); chk("R4 repeated arm expiry", irq, 1);
  endtask

  task automatic t_pending();
    do_reset();
    wr(A_CTRL, 8'h05);
    wait_n(7); chk("R5 old period still active (pre)", irq, 0);
    wait_n(1); chk("R5 old period still active", irq, 1);
    iack = 1'b1; @(negedge clk); iack = 1'b0;
    service();
    chk("R5 after commit", irq, 0);
    wait_n(31); chk("R3/R5 sel1 not yet", irq, 0);
    wait_n(1);  chk("R3/R5 sel1 expiry", irq, 1);
  endtask

  task automatic t_prescale(input logic [7:0] ctrl, input int len, input string tag);
    do_reset();
    wr(A_CTRL, ctrl);
    service();
    wait_n(len - 1); chk({"R3 ", tag, " not yet"}, irq, 0);
    wait_n(1);       chk({"R3 ", tag, " expiry"}, irq, 1);
  endtask

  task automatic t_ta();
    logic [7:0] d;
    do_reset();
    wr(A_CTRL, 8'h11);
    wait_n(8); chk("R8 first expiry", irq, 1);
    wait_n(7); chk("R8 ta not yet", ta, 0);
    wait_n(1); chk("R8 ta fires", ta, 1);
    rd(A_CTRL, d); chk("R10 flag set", d[5], 1);
    wait_n(1); chk("R8 ta one cycle", ta, 0);
    wr(A_CTRL, 8'h11);
    rd(A_CTRL, d); chk("R10 write 0 keeps flag", d[5], 1);
    wr(A_CTRL, 8'h31);
    rd(A_CTRL, d); chk("R10 write 1 clears flag", d[5], 0);
    chk("R6 irq still pending", irq, 1);
  endtask

  task automatic t_ta_off();
    logic [7:0] d;
    int seen = 0;
    do_reset();
    wr(A_CTRL, 8'h01);
    wait_n(8); chk("R9 expiry", irq, 1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (ta) seen++;
    end
    chk("R9 no ta when disabled", seen, 0);
    rd(A_CTRL, d); chk("R9 flag stays clear", d[5], 0);
  endtask

  task automatic t_disabled();
    int seen = 0;
    do_reset();
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (irq) seen++;
    end
    chk("R12 no expiry while off", seen, 0);
    wr(A_CTRL, 8'h01);
    wait_n(4);
    wr(A_CTRL, 8'h00);
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (irq) seen++;
    end
    chk("R12 disable stops count", seen, 0);
  endtask

  task automatic t_reserved();
    logic [7:0] d;
    do_reset();
    wr(A_CTRL, 8'hC1);
    rd(A_CTRL, d); chk("R11 reserved bits read 0", d, 8'h01);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_service();
    t_badseq();
    t_repeat();
    t_pending();
    t_prescale(8'h03, 64,   "pre1 sel0");
    t_prescale(8'h0D, 512,  "pre0 sel3");
    t_prescale(8'h0F, 4096, "pre1 sel3");
    t_ta();
    t_ta_off();
    t_disabled();
    t_reserved();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired t=%0t", $time);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule